// File: doc/BRIEF.md
# Banked Address-Map Decoder for an 8-bit Console Bus

This block sits between an 8-bit CPU and the memories of a small handheld console. Each request carries a 16-bit address. The block captures the request and splits the address space into regions. It then sends each access to one downstream target over a shared bus: a one-hot target select, a physical address inside that target, a write strobe and write data. The byte that comes back from the selected target is returned to the CPU.

The targets are the cartridge ROM (a fixed bank and a switchable bank), the cartridge bank controller (which receives every write into the ROM area), video RAM, cartridge RAM, work RAM, sprite attribute RAM and the I/O register file. Four small items live inside the block: the work-RAM bank register, the interrupt-enable byte, high RAM and the access rules. The access rules cover the work-RAM bank alias, the echo mirror, sprite RAM gated by the video mode, cartridge RAM gated by its enable, and the unusable window. Any read that the access rules refuse returns 0xFF.

The bench model holds the large storage arrays. The ROM bank number comes in from the bank controller.

Top module: `hbus_map_decoder`

## Requirements
- R1: After a synchronous reset, the state is as follows: `cpu_rdata` is 0x00, `cpu_rvalid` is 0, no `dn_sel` bit is set, `dn_we` is 0, the work-RAM bank is 1 and the interrupt-enable byte is 0.
- R2: A request is captured on a rising edge. The resulting read byte appears on `cpu_rdata`, with `cpu_rvalid` high, after the next rising edge. For a write, `dn_we` and `dn_sel` are driven in the cycle after capture. A write has priority over a read in the same cycle, and a read never raises `dn_we`.
- R3: Reads of 0x0000–0x3FFF select target bit 0 (ROM) with physical address equal to the low 14 address bits. Reads of 0x4000–0x7FFF select ROM with physical address {`rom_bank_sel`, low 14 bits}.
- R4: A write anywhere in 0x0000–0x7FFF selects target bit 1 (bank controller), with `dn_addr` equal to the full 16-bit address and `dn_wdata` equal to the value. It never reaches ROM, and later ROM reads are unchanged.
- R5: A write to 0xFF70 sets the work-RAM bank to the value's low 3 bits, and a value of 0 gives bank 1. Reading 0xFF70 returns 0xF8 OR bank. The new bank applies to requests captured from the edge after the write's capture.
- R6: Addresses 0xC000–0xCFFF select target bit 4 (work RAM) at physical {0, low 12 bits}. Addresses 0xD000–0xDFFF select work RAM at {bank, low 12 bits}.
- R7: Addresses 0xE000–0xEFFF mirror 0xC000–0xCFFF, and 0xF000–0xFDFF mirror the banked window at the same low 12 bits.
- R8: Addresses 0xFE00–0xFE9F select target bit 5 (sprite RAM, physical = low 8 bits) only while `vid_mode` is 0 or 1. In modes 2 and 3, reads return 0xFF and writes are dropped.
- R9: Addresses 0xFEA0–0xFEFF select no target. Reads there return 0xFF and writes there change nothing.
- R10: Addresses 0xA000–0xBFFF select target bit 3 (cartridge RAM, physical = low 13 bits) when `xram_on` or `clkreg_sel` is high. When both are low, reads return 0xFF and writes are dropped.
- R11: Addresses 0x8000–0x9FFF select target bit 2 (video RAM, low 13 bits). Addresses 0xFF00–0xFF7F other than 0xFF70 select target bit 6 (I/O, low 7 bits). Addresses 0xFF80–0xFFFE are internal high RAM, and 0xFFFF is the internal interrupt-enable byte, both readable back.
- R12: At most one bit of `dn_sel` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Registered read byte |
| cpu_rvalid | output | 1 | Read byte valid |
| vid_mode | input | 2 | Current video mode |
| xram_on | input | 1 | Cartridge RAM enabled |
| clkreg_sel | input | 1 | Cartridge clock register selected (also opens the window) |
| rom_bank_sel | input | ROM_BANK_W | Switchable ROM bank from the bank controller |
| dn_sel | output | 7 | One-hot target select |
| dn_addr | output | DN_AW | Physical address inside the target |
| dn_we | output | 1 | Downstream write strobe |
| dn_wdata | output | 8 | Downstream write byte |
| dn_rdata | input | 8 | Byte returned by the selected target |

## Verification
Directed sequences come first. The same work-RAM offset is written under two different banks, which tells the banked window apart from the fixed one and from the echo mirror. Sprite RAM and cartridge RAM are each accessed once with the gate open and once with it closed. Bank value 0 is written to show that it gives bank 1, and a ROM-area write is followed by a read-back of the same location. After that, a seeded random mix of reads and writes is spread over every region with random mode, enable and ROM-bank settings. A stale bank, a swapped mirror or a missing gate shows up as a wrong byte on a later read.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int TGT_N       = 7;
  localparam int ROM_OFF_W   = 14;
  localparam int WRAM_OFF_W  = 12;
  localparam int VRAM_OFF_W  = 13;
  localparam int XRAM_OFF_W  = 13;
  localparam int OAM_OFF_W   = 8;
  localparam int IO_OFF_W    = 7;
  localparam int HRAM_DEPTH  = 127;
  localparam logic [7:0] OPEN_BUS = 8'hFF;

  // downstream target index (bit position in dn_sel)
  typedef enum logic [2:0] {
    TG_ROM  = 3'd0,
    TG_CTRL = 3'd1,
    TG_VRAM = 3'd2,
    TG_XRAM = 3'd3,
    TG_WRAM = 3'd4,
    TG_OAM  = 3'd5,
    TG_IO   = 3'd6
  } tgt_e;

  // where an access is served
  typedef enum logic [2:0] {
    RT_NONE  = 3'd0,
    RT_EXT   = 3'd1,
    RT_HRAM  = 3'd2,
    RT_IE    = 3'd3,
    RT_WBANK = 3'd4
  } route_e;
endpackage

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
#(
  parameter int          ROM_BANK_W = 7,
  parameter int          WB_W       = 3,
  parameter int          DN_AW      = 21,
  parameter logic [15:0] WBANK_ADDR = 16'hFF70
) (
  input  logic [15:0]           addr,
  input  logic                  is_wr,
  input  logic [1:0]            vmode,
  input  logic                  xram_on,
  input  logic                  clkreg_sel,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [WB_W-1:0]       wbank,
  output route_e                route,
  output tgt_e                  tgt,
  output logic [DN_AW-1:0]      dn_addr
);
  logic [DN_AW-1:0] fixed_wram;
  logic [DN_AW-1:0] banked_wram;

  assign fixed_wram  = DN_AW'(addr[WRAM_OFF_W-1:0]);
  assign banked_wram = DN_AW'({wbank, addr[WRAM_OFF_W-1:0]});

  always_comb begin
    route   = RT_NONE;
    tgt     = TG_ROM;
    dn_addr = '0;
    case (addr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        route = RT_EXT;
        if (is_wr) begin
          tgt     = TG_CTRL;
          dn_addr = DN_AW'(addr);
        end else begin
          tgt     = TG_ROM;
          dn_addr = DN_AW'(addr[ROM_OFF_W-1:0]);
        end
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        route = RT_EXT;
        if (is_wr) begin
          tgt     = TG_CTRL;
          dn_addr = DN_AW'(addr);
        end else begin
          tgt     = TG_ROM;
          dn_addr = DN_AW'({rom_bank, addr[ROM_OFF_W-1:0]});
        end
      end
      4'h8, 4'h9: begin
        route   = RT_EXT;
        tgt     = TG_VRAM;
        dn_addr = DN_AW'(addr[VRAM_OFF_W-1:0]);
      end
      4'hA, 4'hB: begin
        if (xram_on || clkreg_sel) begin
          route   = RT_EXT;
          tgt     = TG_XRAM;
          dn_addr = DN_AW'(addr[XRAM_OFF_W-1:0]);
        end
      end
      4'hC, 4'hE: begin
        route   = RT_EXT;
        tgt     = TG_WRAM;
        dn_addr = fixed_wram;
      end
      4'hD: begin
        route   = RT_EXT;
        tgt     = TG_WRAM;
        dn_addr = banked_wram;
      end
      default: begin
        if (addr < 16'hFE00) begin
          route   = RT_EXT;
          tgt     = TG_WRAM;
          dn_addr = banked_wram;
        end else if (addr < 16'hFEA0) begin
          if (vmode < 2'd2) begin
            route   = RT_EXT;
            tgt     = TG_OAM;
            dn_addr = DN_AW'(addr[OAM_OFF_W-1:0]);
          end
        end else if (addr < 16'hFF00) begin
          route = RT_NONE;
        end else if (addr < 16'hFF80) begin
          if (addr == WBANK_ADDR) begin
            route = RT_WBANK;
          end else begin
            route   = RT_EXT;
            tgt     = TG_IO;
            dn_addr = DN_AW'(addr[IO_OFF_W-1:0]);
          end
        end else if (addr != 16'hFFFF) begin
          route = RT_HRAM;
        end else begin
          route = RT_IE;
        end
      end
    endcase
  end
endmodule

// File: rtl/hbus_wbank.sv
module hbus_wbank #(
  parameter int WB_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [WB_W-1:0] wval,
  output logic [WB_W-1:0] bank
);
  // the zero alias is resolved here, so the decode path never compares
  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= WB_W'(1);
    end else if (we) begin
      bank <= (wval == '0) ? WB_W'(1) : wval;
    end
  end
endmodule

// File: rtl/hbus_hram.sv
module hbus_hram #(
  parameter int DEPTH = 127,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hbus_map_decoder.sv
module hbus_map_decoder
  import hbus_pkg::*;
#(
  parameter int          ROM_BANK_W = 7,
  parameter int          WB_W       = 3,
  parameter logic [15:0] WBANK_ADDR = 16'hFF70,
  localparam int ROM_AW  = ROM_BANK_W + ROM_OFF_W,
  localparam int WRAM_AW = WB_W + WRAM_OFF_W,
  localparam int AW_A    = (ROM_AW > WRAM_AW) ? ROM_AW : WRAM_AW,
  localparam int DN_AW   = (AW_A > 16) ? AW_A : 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [15:0]           cpu_addr,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [7:0]            cpu_wdata,
  output logic [7:0]            cpu_rdata,
  output logic                  cpu_rvalid,
  input  logic [1:0]            vid_mode,
  input  logic                  xram_on,
  input  logic                  clkreg_sel,
  input  logic [ROM_BANK_W-1:0] rom_bank_sel,
  output logic [TGT_N-1:0]      dn_sel,
  output logic [DN_AW-1:0]      dn_addr,
  output logic                  dn_we,
  output logic [7:0]            dn_wdata,
  input  logic [7:0]            dn_rdata
);
  localparam int HRAM_AW = $clog2(HRAM_DEPTH);

  // request stage
  logic [15:0]           q_addr;
  logic                  q_rd;
  logic                  q_wr;
  logic [7:0]            q_wdata;
  logic [1:0]            q_vmode;
  logic                  q_xon;
  logic                  q_ckr;
  logic [ROM_BANK_W-1:0] q_rbank;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_rd <= 1'b0;
      q_wr <= 1'b0;
    end else begin
      q_rd <= cpu_rd & ~cpu_wr;
      q_wr <= cpu_wr;
    end
    q_addr  <= cpu_addr;
    q_wdata <= cpu_wdata;
    q_vmode <= vid_mode;
    q_xon   <= xram_on;
    q_ckr   <= clkreg_sel;
    q_rbank <= rom_bank_sel;
  end

  logic [WB_W-1:0] wbank_q;
  route_e          route;
  tgt_e            tgt;
  logic [DN_AW-1:0] dec_addr;

  hbus_decode #(
    .ROM_BANK_W (ROM_BANK_W),
    .WB_W       (WB_W),
    .DN_AW      (DN_AW),
    .WBANK_ADDR (WBANK_ADDR)
  ) u_dec (
    .addr       (q_addr),
    .is_wr      (q_wr),
    .vmode      (q_vmode),
    .xram_on    (q_xon),
    .clkreg_sel (q_ckr),
    .rom_bank   (q_rbank),
    .wbank      (wbank_q),
    .route      (route),
    .tgt        (tgt),
    .dn_addr    (dec_addr)
  );

  logic active;
  assign active   = q_rd | q_wr;
  assign dn_sel   = (active && route == RT_EXT) ? (TGT_N'(1) << tgt) : '0;
  assign dn_we    = q_wr && (route == RT_EXT);
  assign dn_addr  = dec_addr;
  assign dn_wdata = q_wdata;

  hbus_wbank #(.WB_W(WB_W)) u_wbank (
    .clk  (clk),
    .rst  (rst),
    .we   (q_wr && route == RT_WBANK),
    .wval (q_wdata[WB_W-1:0]),
    .bank (wbank_q)
  );

  logic [7:0] hram_rd;

  hbus_hram #(.DEPTH(HRAM_DEPTH), .DW(8)) u_hram (
    .clk   (clk),
    .we    (q_wr && route == RT_HRAM),
    .waddr (q_addr[HRAM_AW-1:0]),
    .wdata (q_wdata),
    .raddr (q_addr[HRAM_AW-1:0]),
    .rdata (hram_rd)
  );

  logic [7:0] ie_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 8'h00;
    end else if (q_wr && route == RT_IE) begin
      ie_q <= q_wdata;
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (route)
      RT_EXT:   rd_mux = dn_rdata;
      RT_HRAM:  rd_mux = hram_rd;
      RT_IE:    rd_mux = ie_q;
      RT_WBANK: rd_mux = {{(8-WB_W){1'b1}}, wbank_q};
      default:  rd_mux = OPEN_BUS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata  <= 8'h00;
      cpu_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= q_rd;
      if (q_rd) cpu_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/hbus_map_checker.sv
module hbus_map_checker #(
  parameter int WB_W  = 3,
  parameter int TGT_N = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [15:0]      cpu_addr,
  input logic             cpu_rd,
  input logic             cpu_wr,
  input logic [1:0]       vid_mode,
  input logic             xram_on,
  input logic             clkreg_sel,
  input logic [7:0]       cpu_rdata,
  input logic             cpu_rvalid,
  input logic [TGT_N-1:0] dn_sel,
  input logic             dn_we,
  input logic [WB_W-1:0]  wbank_q
);
  a_r12_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_sel));

  a_r5_bank_nonzero: assert property (@(posedge clk) disable iff (rst)
    wbank_q != '0);

  a_r4_rom_wr_ctrl: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_addr[15]) |=> (dn_sel[1] && $countones(dn_sel) == 1 && dn_we));

  a_r8_oam_blocked: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr >= 16'hFE00 && cpu_addr < 16'hFEA0 && vid_mode[1])
      |=> ##1 (cpu_rdata == 8'hFF));

  a_r9_unusable_ff: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr >= 16'hFEA0 && cpu_addr < 16'hFF00)
      |=> ##1 (cpu_rdata == 8'hFF));

  a_r10_xram_closed: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr[15:13] == 3'b101 && !xram_on && !clkreg_sel)
      |=> (!dn_we && dn_sel == '0));

  a_r2_read_valid: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr) |=> (!dn_we ##1 cpu_rvalid));
endmodule

bind hbus_map_decoder hbus_map_checker #(.WB_W(WB_W), .TGT_N(hbus_pkg::TGT_N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .vid_mode   (vid_mode),
  .xram_on    (xram_on),
  .clkreg_sel (clkreg_sel),
  .cpu_rdata  (cpu_rdata),
  .cpu_rvalid (cpu_rvalid),
  .dn_sel     (dn_sel),
  .dn_we      (dn_we),
  .wbank_q    (wbank_q)
);

// File: tb/tb_hbus_map_decoder.sv
`timescale 1ns/1ps
module tb_hbus_map_decoder;
  localparam int RBW = 7;
  localparam int DAW = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic cpu_rvalid;
  logic [1:0] vid_mode = 2'd0;
  logic xram_on = 1'b1, clkreg_sel = 1'b0;
  logic [RBW-1:0] rom_bank_sel = RBW'(1);
  logic [6:0] dn_sel;
  logic [DAW-1:0] dn_addr;
  logic dn_we;
  logic [7:0] dn_wdata;
  logic [7:0] dn_rdata = 8'h00;

  always #2.5 clk = ~clk;

  hbus_map_decoder dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .vid_mode(vid_mode), .xram_on(xram_on), .clkreg_sel(clkreg_sel),
    .rom_bank_sel(rom_bank_sel), .dn_sel(dn_sel), .dn_addr(dn_addr), .dn_we(dn_we),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [7:0] bg(input int key);
    return key[7:0] ^ key[15:8] ^ key[23:16] ^ 8'h5A;
  endfunction

  function automatic int mk(input int t, input int phys);
    return (t << DAW) | phys;
  endfunction

  // ---------- harness storage (downstream targets) ----------
  logic [7:0] hmem [int];
  logic [15:0] ctl_addr = '0;
  logic [7:0]  ctl_data = '0;

  function automatic int sel_idx(input logic [6:0] s);
    for (int i = 0; i < 7; i++) if (s[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (dn_we && dn_sel != '0) begin
      if (dn_sel[1]) begin
        ctl_addr <= dn_addr[15:0];
        ctl_data <= dn_wdata;
      end else begin
        hmem[mk(sel_idx(dn_sel), int'(dn_addr))] = dn_wdata;
      end
    end
  end

  always @(negedge clk) begin
    int k;
    k = mk(sel_idx(dn_sel), int'(dn_addr));
    if (dn_sel == '0) dn_rdata <= 8'h00;
    else if (hmem.exists(k)) dn_rdata <= hmem[k];
    else dn_rdata <= bg(k);
  end

  // ---------- reference model from the requirements ----------
  logic [7:0] mdl [int];
  logic [7:0] m_hram [127];
  logic [7:0] m_ie = 8'h00;
  int m_bank = 1;

  function automatic logic [7:0] look(input int key);
    return mdl.exists(key) ? mdl[key] : bg(key);
  endfunction

  // returns key, or -1 for internal/none; kind: 0 ext,1 none,2 hram,3 ie,4 wbank
  function automatic int map_key(input logic [15:0] a, output int kind);
    kind = 0;
    if (a < 16'h4000) return mk(0, int'(a[13:0]));
    if (a < 16'h8000) return mk(0, (int'(rom_bank_sel) << 14) | int'(a[13:0]));
    if (a < 16'hA000) return mk(2, int'(a[12:0]));
    if (a < 16'hC000) begin
      if (xram_on || clkreg_sel) return mk(3, int'(a[12:0]));
      kind = 1; return -1;
    end
    if (a < 16'hD000 || (a >= 16'hE000 && a < 16'hF000)) return mk(4, int'(a[11:0]));
    if (a < 16'hFE00) return mk(4, (m_bank << 12) | int'(a[11:0]));
    if (a < 16'hFEA0) begin
      if (vid_mode < 2'd2) return mk(5, int'(a[7:0]));
      kind = 1; return -1;
    end
    if (a < 16'hFF00) begin kind = 1; return -1; end
    if (a == 16'hFF70) begin kind = 4; return -1; end
    if (a < 16'hFF80) return mk(6, int'(a[6:0]));
    if (a != 16'hFFFF) begin kind = 2; return -1; end
    kind = 3; return -1;
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    int kind, key;
    key = map_key(a, kind);
    case (kind)
      0: return look(key);
      2: return m_hram[a[6:0]];
      3: return m_ie;
      4: return 8'hF8 | 8'(m_bank);
      default: return 8'hFF;
    endcase
  endfunction

  function automatic void exp_write(input logic [15:0] a, input logic [7:0] d);
    int kind, key;
    if (a < 16'h8000) return;            // forwarded to the controller only
    key = map_key(a, kind);
    case (kind)
      0: mdl[key] = d;
      2: m_hram[a[6:0]] = d;
      3: m_ie = d;
      4: m_bank = (d[2:0] == 3'd0) ? 1 : int'(d[2:0]);
      default: ;
    endcase
  endfunction

  // ---------- stimulus tasks ----------
  task automatic check(input string tag, input logic [15:0] a, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%04h got=%02h expected=%02h", tag, a, got, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
    exp_write(a, d);
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    @(negedge clk);
    cpu_rd = 1'b0;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a);
    logic [7:0] got, exp;
    exp = exp_read(a);
    do_read(a, got);
    check(tag, a, got, exp);
  endtask

  function automatic logic [15:0] rnd_addr();
    logic [15:0] base;
    case ($urandom % 14)
      0: base = 16'h0000;  1: base = 16'h4000;  2: base = 16'h8000;
      3: base = 16'hA000;  4: base = 16'hC000;  5: base = 16'hD000;
      6: base = 16'hE000;  7: base = 16'hF000;  8: base = 16'hFE00;
      9: base = 16'hFEA0; 10: base = 16'hFF00; 11: base = 16'hFF70;
      12: base = 16'hFF80; default: base = 16'hFFF0;
    endcase
    return base + 16'($urandom % 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata after reset", 16'h0, cpu_rdata, 8'h00);
    check("R1 rvalid after reset", 16'h0, {7'd0, cpu_rvalid}, 8'h00);
    check("R1 no target after reset", 16'h0, {1'b0, dn_sel}, 8'h00);
    rd_chk("R1 IE reset value", 16'hFFFF);
    rd_chk("R1 bank reset value", 16'hFF70);
    // preload high RAM so every later read is defined
    for (int i = 0; i < 127; i++) do_write(16'hFF80 + 16'(i), 8'(i * 7 + 3));
    rd_chk("R11 hram readback", 16'hFF80);
    rd_chk("R11 hram top", 16'hFFFE);
    // R2 latency: read lands exactly one edge after capture edge
    @(negedge clk); cpu_addr = 16'hFFFF; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
    check("R2 rvalid low before data edge", 16'hFFFF, {7'd0, cpu_rvalid}, 8'h00);
    @(negedge clk);
    check("R2 rvalid at data edge", 16'hFFFF, {7'd0, cpu_rvalid}, 8'h01);
    // R3 ROM
    rom_bank_sel = RBW'(5);
    rd_chk("R3 fixed rom", 16'h1234);
    rd_chk("R3 banked rom b5", 16'h5234);
    rom_bank_sel = RBW'(9);
    rd_chk("R3 banked rom b9", 16'h5234);
    // R4 controller write
    do_write(16'h2100, 8'h3C);
    @(negedge clk);
    check("R4 ctrl addr lo", 16'h2100, ctl_addr[7:0], 8'h00);
    check("R4 ctrl addr hi", 16'h2100, ctl_addr[15:8], 8'h21);
    check("R4 ctrl data", 16'h2100, ctl_data, 8'h3C);
    rd_chk("R4 rom unchanged", 16'h2100);
    // R5 / R6 / R7 banks and mirrors
    do_write(16'hFF70, 8'h02);
    do_write(16'hD010, 8'hA2);
    do_write(16'hFF70, 8'h0B);        // low bits 3
    do_write(16'hD010, 8'hB3);
    rd_chk("R5 bank low bits", 16'hFF70);
    rd_chk("R6 bank3 data", 16'hD010);
    do_write(16'hFF70, 8'h02);
    rd_chk("R6 bank2 data kept", 16'hD010);
    rd_chk("R7 upper echo follows bank", 16'hF010);
    do_write(16'hFF70, 8'h00);
    rd_chk("R5 zero selects bank1", 16'hFF70);
    do_write(16'hC020, 8'h11);
    rd_chk("R7 lower echo", 16'hE020);
    do_write(16'hE021, 8'h22);
    rd_chk("R6 fixed via echo write", 16'hC021);
    // R8 sprite RAM gating
    vid_mode = 2'd1; do_write(16'hFE10, 8'h77);
    vid_mode = 2'd3; do_write(16'hFE10, 8'h99);
    rd_chk("R8 blocked read", 16'hFE10);
    vid_mode = 2'd0;
    rd_chk("R8 blocked write dropped", 16'hFE10);
    // R9 unusable
    do_write(16'hFEB0, 8'h42);
    rd_chk("R9 unusable read", 16'hFEB0);
    // R10 cartridge RAM gating
    xram_on = 1'b1; do_write(16'hA005, 8'h5E);
    xram_on = 1'b0; do_write(16'hA005, 8'h6F);
    rd_chk("R10 closed read", 16'hA005);
    clkreg_sel = 1'b1;
    rd_chk("R10 clock select opens", 16'hA005);
    clkreg_sel = 1'b0; xram_on = 1'b1;
    // R11 video / IO / IE
    do_write(16'h8123, 8'h81); rd_chk("R11 vram", 16'h8123);
    do_write(16'hFF41, 8'h14); rd_chk("R11 io", 16'hFF41);
    do_write(16'hFFFF, 8'h1F); rd_chk("R11 ie", 16'hFFFF);
    // random mix, R12 checked by assertion alongside
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      vid_mode     = 2'($urandom);
      xram_on      = ($urandom % 3) != 0;
      clkreg_sel   = ($urandom % 5) == 0;
      rom_bank_sel = RBW'($urandom);
      a = rnd_addr();
      if ($urandom % 2) do_write(a, 8'($urandom));
      else rd_chk("R12 random access", a);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule